// File: doc/BRIEF.md
# Sobel Edge Mask Generator

This block turns a grayscale pixel stream into a one-bit edge mask stream. Each input sample carries a valid flag and two sync tags: one marks the first pixel of a row and one marks the first pixel of a frame. Two line buffers keep the two previous rows. Together with the current pixel they form a 3x3 neighbourhood. Horizontal and vertical Sobel gradients are formed over that neighbourhood using only shifts, adds and subtracts. The block sums their absolute values, scales the sum by a gain and compares the result with a threshold. The result is one mask bit for every valid input pixel.

The pipeline advances on every clock, so idle cycles between valid samples are allowed. The neighbourhood moves forward only on valid samples. Pixels that would lie left of column 0 or above row 0 of the frame are read as zero. The gain and threshold are captured on the first pixel of each frame and travel down the pipeline with the samples of that frame. A new setting therefore never changes pixels that are still in flight from the previous frame. The valid flag and both tags come out aligned with the mask bit they belong to.

Top module: `edge_mask_gen`

## Requirements
- R1: For every clock edge at which `valid_i` is sampled, `valid_o` shows the same value exactly five clock edges later. The fixed latency is 5 cycles.
- R2: `hsync_o` and `vsync_o` equal `valid_i & hsync_i` and `valid_i & vsync_i`, delayed by the same 5 cycles. They are 0 on cycles where `valid_o` is 0.
- R3: For the valid pixel at row r, column c of a frame, the window covers rows r-2..r and columns c-2..c. Gx = (right column) - (left column), each column weighted 1,2,1 from top to bottom. Gy = (bottom row) - (top row), each row weighted 1,2,1 from left to right. The magnitude is |Gx| + |Gy|, computed with no overflow for any 8-bit input.
- R4: Window pixels in columns c-1 or c-2 that fall before the sample tagged with `hsync_i` (column 0) read as zero.
- R5: Window pixels in rows r-1 or r-2 that fall before the sample tagged with `vsync_i` (row 0) read as zero. Line buffer contents from an earlier frame have no effect.
- R6: `mask_o` is 1 exactly when gain * magnitude >= threshold, both compared as unsigned values. Equality gives 1. A threshold of 0 gives 1 on every valid pixel.
- R7: Gain and threshold are sampled from `gain_i` and `thr_i` only on a valid sample with `vsync_i` high. Changes on those ports at any other time have no effect on the mask.
- R8: Cycles with `valid_i` low neither advance the neighbourhood nor the row and column position. The values on `pix_i`, `hsync_i` and `vsync_i` during such cycles are ignored.
- R9: While `rst_ni` is low, and in the 5 cycles after it rises, `valid_o`, `hsync_o`, `vsync_o` and `mask_o` are 0.
- R10: `mask_o` is 0 whenever `valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_i | input | PIX_W | Grayscale pixel, unsigned |
| valid_i | input | 1 | Pixel qualifier |
| hsync_i | input | 1 | First pixel of a row |
| vsync_i | input | 1 | First pixel of a frame |
| gain_i | input | GAIN_W | Magnitude gain, unsigned, taken at frame start |
| thr_i | input | THR_W | Mask threshold, unsigned, taken at frame start |
| mask_o | output | 1 | Edge mask bit |
| valid_o | output | 1 | Output qualifier |
| hsync_o | output | 1 | Row start tag, aligned to the mask |
| vsync_o | output | 1 | Frame start tag, aligned to the mask |

## Verification
The bound checker checks on every cycle that the valid flag and both tags are delayed by exactly five cycles, that the mask is never high without valid, and that all outputs stay low during the warm-up after reset. The arithmetic cannot be seen by a property over the ports. This covers the kernel weights, zero fill at the left and top borders, the equality edge of the threshold compare, capture of the settings at frame start, and the freezing of the window during idle cycles. Only the bench scenarios show these, by comparing every mask bit against a behavioural model of the frame.

// File: rtl/edge_pkg.sv
package edge_pkg;

  typedef struct packed {
    logic valid;
    logic hsync;
    logic vsync;
  } tag_t;

  // window, gradient, magnitude, product, compare
  localparam int unsigned PIPE_LAT = 5;

endpackage

// File: rtl/edge_window.sv
module edge_window
  import edge_pkg::*;
#(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned LINE_W = 320,
  parameter int unsigned PRM_W  = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [PIX_W-1:0]            pix_i,
  input  logic                        valid_i,
  input  logic                        hsync_i,
  input  logic                        vsync_i,
  input  logic [PRM_W-1:0]            prm_i,
  output logic [2:0][2:0][PIX_W-1:0]  win_o,   // [col age][rows above]
  output tag_t                        tag_o,
  output logic [PRM_W-1:0]            prm_o
);

  localparam int unsigned TAPS  = 3;
  localparam int unsigned NLB   = TAPS - 1;
  localparam int unsigned COL_W = (LINE_W > 1) ? $clog2(LINE_W) : 1;
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(LINE_W - 1);
  localparam logic [1:0]       ROW_SAT  = 2'(NLB);

  logic [COL_W-1:0] col_q, col_cur;
  logic [1:0]       row_q, row_cur;
  logic [PRM_W-1:0] frm_q, prm_cur;

  logic [PIX_W-1:0]           lb [NLB][LINE_W];
  logic [NLB-1:0][PIX_W-1:0]  lb_rd;
  logic [NLB:0][PIX_W-1:0]    col_v;
  logic [NLB:0][PIX_W-1:0]    prev1_q, prev2_q, eff1, eff2;

  assign col_cur = (hsync_i || vsync_i) ? '0 : col_q;

  always_comb begin
    if (vsync_i)      row_cur = 2'd0;
    else if (hsync_i) row_cur = (row_q == ROW_SAT) ? ROW_SAT : row_q + 2'd1;
    else              row_cur = row_q;
  end

  assign prm_cur = vsync_i ? prm_i : frm_q;

  // line buffer taps, gated to zero above the top row of the frame
  assign col_v[0] = pix_i;
  for (genvar k = 1; k <= NLB; k++) begin : g_tap
    assign lb_rd[k-1] = lb[k-1][col_cur];
    assign col_v[k]   = (row_cur >= 2'(k)) ? lb_rd[k-1] : '0;
  end

  always_ff @(posedge clk_i) begin
    if (valid_i) begin
      lb[0][col_cur] <= pix_i;
      for (int j = 1; j < NLB; j++) lb[j][col_cur] <= lb_rd[j-1];
    end
  end

  // left-of-row columns read as zero on the row's first pixel
  assign eff1 = hsync_i || vsync_i ? '0 : prev1_q;
  assign eff2 = hsync_i || vsync_i ? '0 : prev2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q   <= '0;
      row_q   <= '0;
      frm_q   <= '0;
      prev1_q <= '0;
      prev2_q <= '0;
      win_o   <= '0;
      prm_o   <= '0;
      tag_o   <= '0;
    end else begin
      tag_o <= '{valid: valid_i, hsync: valid_i & hsync_i, vsync: valid_i & vsync_i};
      if (valid_i) begin
        col_q    <= (col_cur == COL_LAST) ? col_cur : col_cur + COL_W'(1);
        row_q    <= row_cur;
        frm_q    <= prm_cur;
        prev1_q  <= col_v;
        prev2_q  <= eff1;
        win_o[0] <= col_v;
        win_o[1] <= eff1;
        win_o[2] <= eff2;
        prm_o    <= prm_cur;
      end
    end
  end

endmodule

// File: rtl/edge_gradient.sv
module edge_gradient
  import edge_pkg::*;
#(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned PRM_W = 16,
  localparam int unsigned GRAD_W = PIX_W + 3,
  localparam int unsigned MAG_W  = PIX_W + 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [2:0][2:0][PIX_W-1:0]  win_i,
  input  tag_t                        tag_i,
  input  logic [PRM_W-1:0]            prm_i,
  output logic [MAG_W-1:0]            mag_o,
  output tag_t                        tag_o,
  output logic [PRM_W-1:0]            prm_o
);

  function automatic logic signed [GRAD_W-1:0] sx(input logic [PIX_W-1:0] p);
    return signed'({{(GRAD_W-PIX_W){1'b0}}, p});
  endfunction

  function automatic logic [MAG_W-1:0] absv(input logic signed [GRAD_W-1:0] v);
    return v[GRAD_W-1] ? MAG_W'(-v) : MAG_W'(v);
  endfunction

  logic signed [2:0][GRAD_W-1:0] col_sum, row_sum;
  logic signed [GRAD_W-1:0]      gx_d, gy_d, gx_q, gy_q;
  tag_t                          tag2_q;
  logic [PRM_W-1:0]              prm2_q;

  // col_sum[i]: column of age i weighted down the rows; row_sum[i]: row i above, weighted across
  always_comb begin
    for (int i = 0; i < 3; i++) begin
      col_sum[i] = sx(win_i[i][0]) + (sx(win_i[i][1]) <<< 1) + sx(win_i[i][2]);
      row_sum[i] = sx(win_i[0][i]) + (sx(win_i[1][i]) <<< 1) + sx(win_i[2][i]);
    end
    gx_d = col_sum[0] - col_sum[2];
    gy_d = row_sum[0] - row_sum[2];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gx_q   <= '0;
      gy_q   <= '0;
      tag2_q <= '0;
      prm2_q <= '0;
      mag_o  <= '0;
      tag_o  <= '0;
      prm_o  <= '0;
    end else begin
      gx_q   <= gx_d;
      gy_q   <= gy_d;
      tag2_q <= tag_i;
      prm2_q <= prm_i;
      mag_o  <= absv(gx_q) + absv(gy_q);
      tag_o  <= tag2_q;
      prm_o  <= prm2_q;
    end
  end

endmodule

// File: rtl/edge_threshold.sv
module edge_threshold
  import edge_pkg::*;
#(
  parameter int unsigned MAG_W  = 11,
  parameter int unsigned GAIN_W = 8,
  parameter int unsigned THR_W  = 8,
  localparam int unsigned PRM_W  = GAIN_W + THR_W,
  localparam int unsigned PROD_W = MAG_W + GAIN_W,
  localparam int unsigned CMP_W  = PROD_W + THR_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [MAG_W-1:0]   mag_i,
  input  tag_t               tag_i,
  input  logic [PRM_W-1:0]   prm_i,   // {gain, threshold}
  output logic               mask_o,
  output tag_t               tag_o
);

  logic [GAIN_W-1:0] gain;
  logic [PROD_W-1:0] prod_q;
  logic [THR_W-1:0]  thr_q;
  tag_t              tag4_q;
  logic [CMP_W-1:0]  prod_x, thr_x;

  assign gain   = prm_i[PRM_W-1:THR_W];
  assign prod_x = {{THR_W{1'b0}}, prod_q};
  assign thr_x  = {{PROD_W{1'b0}}, thr_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q <= '0;
      thr_q  <= '0;
      tag4_q <= '0;
      mask_o <= 1'b0;
      tag_o  <= '0;
    end else begin
      prod_q <= PROD_W'(mag_i) * PROD_W'(gain);
      thr_q  <= prm_i[THR_W-1:0];
      tag4_q <= tag_i;
      mask_o <= tag4_q.valid && (prod_x >= thr_x);
      tag_o  <= tag4_q;
    end
  end

endmodule

// File: rtl/edge_mask_gen.sv
module edge_mask_gen
  import edge_pkg::*;
#(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned LINE_W = 320,
  parameter int unsigned GAIN_W = 8,
  parameter int unsigned THR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PIX_W-1:0]  pix_i,
  input  logic              valid_i,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic [THR_W-1:0]  thr_i,
  output logic              mask_o,
  output logic              valid_o,
  output logic              hsync_o,
  output logic              vsync_o
);

  localparam int unsigned PRM_W = GAIN_W + THR_W;
  localparam int unsigned MAG_W = PIX_W + 3;

  logic [2:0][2:0][PIX_W-1:0] win;
  tag_t                       tag1, tag3, tag5;
  logic [PRM_W-1:0]           prm1, prm3;
  logic [MAG_W-1:0]           mag;

  edge_window #(
    .PIX_W (PIX_W),
    .LINE_W(LINE_W),
    .PRM_W (PRM_W)
  ) u_window (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pix_i  (pix_i),
    .valid_i(valid_i),
    .hsync_i(hsync_i),
    .vsync_i(vsync_i),
    .prm_i  ({gain_i, thr_i}),
    .win_o  (win),
    .tag_o  (tag1),
    .prm_o  (prm1)
  );

  edge_gradient #(
    .PIX_W(PIX_W),
    .PRM_W(PRM_W)
  ) u_gradient (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .win_i (win),
    .tag_i (tag1),
    .prm_i (prm1),
    .mag_o (mag),
    .tag_o (tag3),
    .prm_o (prm3)
  );

  edge_threshold #(
    .MAG_W (MAG_W),
    .GAIN_W(GAIN_W),
    .THR_W (THR_W)
  ) u_threshold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mag_i (mag),
    .tag_i (tag3),
    .prm_i (prm3),
    .mask_o(mask_o),
    .tag_o (tag5)
  );

  assign valid_o = tag5.valid;
  assign hsync_o = tag5.hsync;
  assign vsync_o = tag5.vsync;

endmodule

// File: rtl/edge_mask_chk.sv
module edge_mask_chk
  import edge_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic hsync_i,
  input logic vsync_i,
  input logic mask_o,
  input logic valid_o,
  input logic hsync_o,
  input logic vsync_o
);

  localparam logic [2:0] LAT = 3'(PIPE_LAT);

  logic [2:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cyc_q <= '0;
    else if (cyc_q < LAT) cyc_q <= cyc_q + 3'd1;
  end

  assert_valid_delay_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= LAT) |-> (valid_o == $past(valid_i, 5)));

  assert_hsync_delay_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= LAT) |-> (hsync_o == $past(valid_i && hsync_i, 5)));

  assert_vsync_delay_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= LAT) |-> (vsync_o == $past(valid_i && vsync_i, 5)));

  assert_warmup_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q < LAT) |-> !(valid_o || hsync_o || vsync_o || mask_o));

  assert_mask_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_o |-> valid_o);

endmodule

bind edge_mask_gen edge_mask_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .hsync_i(hsync_i),
  .vsync_i(vsync_i),
  .mask_o (mask_o),
  .valid_o(valid_o),
  .hsync_o(hsync_o),
  .vsync_o(vsync_o)
);

// File: tb/tb_edge_mask_gen.sv
`timescale 1ns/1ps
module tb_edge_mask_gen;

  localparam int LW  = 8;
  localparam int LAT = 5;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] pix_i = '0;
  logic       valid_i = 1'b0, hsync_i = 1'b0, vsync_i = 1'b0;
  logic [7:0] gain_i = '0, thr_i = '0;
  logic       mask_o, valid_o, hsync_o, vsync_o;

  int n_checks = 0;
  int n_errors = 0;

  int          img [8][8];
  int unsigned seed = 32'h1234_5678;

  logic  pv  [LAT];
  logic  ph  [LAT];
  logic  pvs [LAT];
  logic  pm  [LAT];
  string preq[LAT];

  always #4 clk = ~clk;

  edge_mask_gen #(.PIX_W(8), .LINE_W(LW), .GAIN_W(8), .THR_W(8)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .pix_i(pix_i), .valid_i(valid_i),
    .hsync_i(hsync_i), .vsync_i(vsync_i), .gain_i(gain_i), .thr_i(thr_i),
    .mask_o(mask_o), .valid_o(valid_o), .hsync_o(hsync_o), .vsync_o(vsync_o)
  );

  task automatic chk(input logic act, input logic exp, input string rq, input string what);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", rq, what, act, exp, $time);
    end
  endtask

  function automatic int px(input int r, input int c);
    if (r < 0 || c < 0) return 0;
    return img[r][c];
  endfunction

  // behavioural Sobel: window rows r-2..r, cols c-2..c
  function automatic logic model(input int r, input int c, input int g, input int t);
    int gx, gy, m;
    gx = (px(r-2,c) + 2*px(r-1,c) + px(r,c)) - (px(r-2,c-2) + 2*px(r-1,c-2) + px(r,c-2));
    gy = (px(r,c-2) + 2*px(r,c-1) + px(r,c)) - (px(r-2,c-2) + 2*px(r-2,c-1) + px(r-2,c));
    m  = (gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy);
    return (g * m) >= t;
  endfunction

  task automatic step(input logic v, input logic [7:0] p, input logic hs, input logic vs,
                      input logic [7:0] g, input logic [7:0] t, input logic em, input string rq);
    @(negedge clk);
    chk(valid_o, pv[LAT-1], "R1", "valid_o");
    chk(hsync_o, ph[LAT-1], "R2", "hsync_o");
    chk(vsync_o, pvs[LAT-1], "R2", "vsync_o");
    chk(mask_o, pm[LAT-1], pv[LAT-1] ? preq[LAT-1] : "R10", "mask_o");
    for (int i = LAT-1; i > 0; i--) begin
      pv[i] = pv[i-1]; ph[i] = ph[i-1]; pvs[i] = pvs[i-1]; pm[i] = pm[i-1]; preq[i] = preq[i-1];
    end
    pv[0] = v; ph[0] = v & hs; pvs[0] = v & vs; pm[0] = v & em; preq[0] = rq;
    valid_i = v; pix_i = p; hsync_i = hs; vsync_i = vs; gain_i = g; thr_i = t;
  endtask

  // idle cycle with junk on the ignored inputs (R8)
  task automatic idle(input logic [7:0] g, input logic [7:0] t);
    step(1'b0, 8'hA5, 1'b1, 1'b1, g, t, 1'b0, "R8");
  endtask

  task automatic run_frame(input int rows, input int cols, input int pat, input int g,
                           input int t, input bit gaps, input bit mid, input string lbl);
    for (int r = 0; r < rows; r++)
      for (int c = 0; c < cols; c++) begin
        case (pat)
          0: begin seed = seed * 1103515245 + 12345; img[r][c] = int'(seed[23:16]); end
          1: img[r][c] = (c >= 3) ? 30 : 10;
          default: img[r][c] = 255;
        endcase
      end
    for (int r = 0; r < rows; r++)
      for (int c = 0; c < cols; c++) begin
        logic [7:0] gd, td;
        string rq;
        if (gaps && ((r*cols + c) % 3 == 1)) idle(8'h11, 8'h22);
        gd = (mid && !(r == 0 && c == 0)) ? ~8'(g) : 8'(g);
        td = (mid && !(r == 0 && c == 0)) ? 8'(t) ^ 8'h5A : 8'(t);
        rq = (r < 2) ? "R5" : (c < 2) ? "R4" : lbl;
        step(1'b1, 8'(img[r][c]), c == 0, r == 0 && c == 0, gd, td, model(r, c, g, t), rq);
      end
    for (int i = 0; i < LAT + 1; i++) idle(8'h00, 8'hFF);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < LAT; i++) begin
      pv[i] = 0; ph[i] = 0; pvs[i] = 0; pm[i] = 0; preq[i] = "R9";
    end
    repeat (3) @(negedge clk);
    chk(valid_o, 1'b0, "R9", "valid_o in reset");
    chk(hsync_o, 1'b0, "R9", "hsync_o in reset");
    chk(vsync_o, 1'b0, "R9", "vsync_o in reset");
    chk(mask_o,  1'b0, "R9", "mask_o in reset");
    rst_ni = 1'b1;

    run_frame(5, 8, 0, 1,   100, 1'b0, 1'b0, "R3");  // random content
    run_frame(5, 8, 0, 2,   180, 1'b1, 1'b0, "R8");  // idle gaps inside the frame
    run_frame(5, 8, 0, 1,   150, 1'b0, 1'b1, "R7");  // settings changed mid-frame
    run_frame(4, 6, 1, 3,   240, 1'b0, 1'b0, "R6");  // step edge, product equals threshold
    run_frame(4, 6, 1, 3,   241, 1'b0, 1'b0, "R6");  // one above
    run_frame(4, 8, 2, 0,   0,   1'b0, 1'b0, "R6");  // zero threshold
    run_frame(5, 8, 2, 255, 255, 1'b0, 1'b0, "R3");  // full-scale pixels and gain

    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule